// File: doc/BRIEF.md
# Vertical Sync and Field Extractor

This block receives a composite sync waveform that an upstream slicer has already turned into a digital level. The level is active low and is sampled on the system clock. From it the block recovers three things. The first is an active-low vertical sync pulse. The second is a field parity flag. The third is a mute strobe, which a horizontal sync generator uses to drop its pulses while the vertical interval is in progress.

The block locks onto the line period by timing the falling edges of the input. It keeps three windows around that period:
- Edges about one line apart are line edges.
- Edges about half a line apart are half-line edges.
- Edges much closer than that are noise.

A low time that exceeds a quarter of the line period marks a broad pulse. The rising edge that ends a broad pulse is a serration, and the first serration starts the vertical pulse. If the input stays low for a whole line with no serration, a default vertical pulse is started instead. The measured line period is available as a status value.

The input is a sampled waveform, not a data stream. It has no valid/ready handshake and cannot apply back-pressure, so a new input sample is taken on every clock. The outputs are registered levels, and the status value is a plain register. With the default single input stage, every result below is given relative to the sample index at which the input changed.

Top module: `vfield_sep`

## Requirements
- R1: After reset, vsync_n is 1, field_odd is 1, hs_mute is 0 and line_period is 0. line_period stays 0 until two falling input edges have been seen.
- R2: line_period equals the spacing in clocks between consecutive falling edges that lie within a quarter line of one line period. Edges at roughly half-line spacing leave it unchanged, and so does a single edge that follows a longer gap.
- R3: When csync_n rises at the end of a low period longer than a quarter of line_period, this is a serration. If the block is armed and no vertical pulse is running, vsync_n goes low two clocks after that rise.
- R4: Every vertical pulse keeps vsync_n low for exactly 3×line_period clocks. After a pulse, the block re-arms only when a low period no longer than a quarter line ends outside a pulse. Until then, further broad pulses start nothing.
- R5: If csync_n stays low for line_period clocks with no serration, a default vertical pulse starts. vsync_n goes low line_period+2 clocks after the falling edge that began the low period.
- R6: hs_mute goes high quarter-line+2 clocks after the falling edge of the first broad pulse. It stays high while vsync_n is low and goes low in the same clock that vsync_n returns high.
- R7: In interlaced mode, field_odd is set when a vertical pulse starts. It is 1 (field 1) if the first broad pulse fell on a line edge and 0 (field 2) if it fell on a half-line edge.
- R8: Interlaced mode requires half-line edges inside the muted window of each of the two most recent vertical intervals. Otherwise field_odd is forced to 1 when each vertical pulse starts.
- R9: field_odd changes only in the clock in which vsync_n falls.
- R10: A constant-high input never starts a vertical pulse, and field_odd keeps its value. After 2^LINE_W−1 clocks with no falling edge, line_period returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csync_n | input | 1 | Sliced composite sync level, low during sync |
| vsync_n | output | 1 | Vertical sync pulse, active low |
| field_odd | output | 1 | 1 for field 1 or progressive, 0 for field 2 |
| hs_mute | output | 1 | High while horizontal sync output must be suppressed |
| line_period | output | LINE_W | Measured line period in clocks, 0 when unlocked |

## Verification
Before each vertical interval is played, the bench works out the sample index of every output edge:
- vsync_n falls two samples after a serration rise, or line_period+2 samples after the fall of an unserrated low period.
- The vertical pulse stays low for 3×line_period samples.
- hs_mute rises quarter-line+2 samples after the first broad fall.
- field_odd changes together with the vsync_n fall.

Every output is then compared against these windows on every sample. Comparisons are made on the falling clock edge, before the next input value is driven, so each due cycle is observed exactly where it is expected. line_period is expected to read 0 before lock and a constant line length afterwards. After the no-signal timeout it is expected to read 0 again.

// File: rtl/vsep_pkg.sv
package vsep_pkg;
  // Classification of one falling edge of the sync input
  typedef enum logic [2:0] {
    EC_NONE,
    EC_NOISE,
    EC_HALF,
    EC_LINE,
    EC_RESYNC
  } edge_cls_t;
endpackage

// File: rtl/vsep_meas.sv
module vsep_meas
  import vsep_pkg::*;
#(
  parameter int LINE_W    = 12,
  parameter int IN_STAGES = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csync_n,
  output logic              fe,
  output logic              re,
  output logic              sync_low,
  output logic [LINE_W-1:0] low_cnt,
  output logic [LINE_W-1:0] line_q,
  output logic              half_evt,
  output logic              last_half
);
  localparam logic [LINE_W-1:0] CMAX = '1;

  logic [IN_STAGES-1:0] chain;
  logic                 s_q, s_d, have_ref;
  logic [LINE_W-1:0]    phase, q4, win_lo;
  logic [LINE_W:0]      win_hi;
  edge_cls_t            cls;

  generate
    if (IN_STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain <= '1;
        else        chain <= csync_n;
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain <= '1;
        else        chain <= {chain[IN_STAGES-2:0], csync_n};
    end
  endgenerate

  assign s_q      = chain[IN_STAGES-1];
  assign fe       = s_d & ~s_q;
  assign re       = ~s_d & s_q;
  assign sync_low = ~s_q;
  assign q4       = line_q >> 2;
  assign win_lo   = line_q - q4;
  assign win_hi   = {1'b0, line_q} + {1'b0, q4};

  always_comb begin
    if (!fe)                       cls = EC_NONE;
    else if (!have_ref)            cls = EC_RESYNC;
    else if (line_q == '0)         cls = EC_LINE;
    else if (phase < q4)           cls = EC_NOISE;
    else if (phase < win_lo)       cls = EC_HALF;
    else if ({1'b0, phase} < win_hi) cls = EC_LINE;
    else                           cls = EC_RESYNC;
  end

  assign half_evt = (cls == EC_HALF);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_d       <= 1'b1;
      low_cnt   <= '0;
      phase     <= '0;
      line_q    <= '0;
      have_ref  <= 1'b0;
      last_half <= 1'b0;
    end else begin
      s_d <= s_q;
      if (fe)                             low_cnt <= 1;
      else if (sync_low && low_cnt != CMAX) low_cnt <= low_cnt + 1'b1;
      case (cls)
        EC_LINE: begin
          line_q    <= phase;
          phase     <= 1;
          last_half <= 1'b0;
        end
        EC_RESYNC: begin
          have_ref  <= 1'b1;
          phase     <= 1;
          last_half <= 1'b0;
        end
        default: begin
          if (cls == EC_HALF) last_half <= 1'b1;
          if (have_ref) begin
            if (phase == CMAX) begin
              have_ref <= 1'b0;
              line_q   <= '0;
            end else begin
              phase <= phase + 1'b1;
            end
          end
        end
      endcase
    end
  end

  AST_HALF_KEEPS_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    (cls == EC_HALF) |=> $stable(line_q)); // R2
endmodule

// File: rtl/vsep_vctl.sv
module vsep_vctl #(
  parameter int LINE_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fe,
  input  logic              re,
  input  logic              sync_low,
  input  logic [LINE_W-1:0] low_cnt,
  input  logic [LINE_W-1:0] line_q,
  output logic              vsync_n,
  output logic              hmute,
  output logic              vs_start,
  output logic              vs_end
);
  localparam int VW = LINE_W + 2;

  logic          broad, armed, active, locked, at_thr, start_ser, start_def;
  logic [LINE_W-1:0] thr;
  logic [VW-1:0] cnt, vlen_q, vlen_full, lowlen;

  assign thr       = line_q >> 2;
  assign locked    = (line_q != '0);
  assign at_thr    = sync_low && locked && (low_cnt == thr);
  assign start_ser = re && broad && armed && !active;
  assign start_def = sync_low && locked && (low_cnt == line_q) && armed && !active;
  assign vs_start  = start_ser | start_def;
  assign vs_end    = active && (cnt == vlen_q);
  assign vlen_full = ({2'b00, line_q} << 1) + {2'b00, line_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      broad   <= 1'b0;
      armed   <= 1'b0;
      active  <= 1'b0;
      cnt     <= '0;
      vlen_q  <= '0;
      vsync_n <= 1'b1;
      hmute   <= 1'b0;
    end else begin
      if (fe)          broad <= 1'b0;
      else if (at_thr) broad <= 1'b1;

      if (vs_start)                             armed <= 1'b0;
      else if (re && !broad && !active && locked) armed <= 1'b1;

      if (vs_start) begin
        active  <= 1'b1;
        cnt     <= 1;
        vlen_q  <= vlen_full;
        vsync_n <= 1'b0;
        hmute   <= 1'b1;
      end else if (vs_end) begin
        active  <= 1'b0;
        vsync_n <= 1'b1;
        hmute   <= 1'b0;
      end else begin
        if (active) cnt <= cnt + 1'b1;
        if (at_thr && armed && !active) hmute <= 1'b1;
      end
    end
  end

  // length of the current low stretch of the vertical output
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        lowlen <= '0;
    else if (!vsync_n) lowlen <= lowlen + 1'b1;
    else               lowlen <= '0;

  AST_VS_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vsync_n) |-> (lowlen == vlen_q)); // R4
  AST_MUTE_COVERS_VS: assert property (@(posedge clk) disable iff (!rst_n)
    !vsync_n |-> hmute); // R6
endmodule

// File: rtl/vsep_field.sv
module vsep_field (
  input  logic clk,
  input  logic rst_n,
  input  logic vs_start,
  input  logic vs_end,
  input  logic hmute,
  input  logic half_evt,
  input  logic last_half,
  output logic field_odd
);
  logic seen, prev_seen, ilace, seen_now;

  assign seen_now = seen | (hmute & half_evt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen      <= 1'b0;
      prev_seen <= 1'b0;
      ilace     <= 1'b0;
      field_odd <= 1'b1;
    end else begin
      if (vs_start) field_odd <= ilace ? !last_half : 1'b1;
      if (vs_end) begin
        ilace     <= seen_now & prev_seen;
        prev_seen <= seen_now;
        seen      <= 1'b0;
      end else if ((hmute && half_evt) || (vs_start && last_half)) begin
        seen <= 1'b1;
      end
    end
  end

  AST_PROG_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (vs_start && !ilace) |=> field_odd); // R8
endmodule

// File: rtl/vfield_sep.sv
module vfield_sep #(
  parameter int LINE_W    = 12,
  parameter int IN_STAGES = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csync_n,
  output logic              vsync_n,
  output logic              field_odd,
  output logic              hs_mute,
  output logic [LINE_W-1:0] line_period
);
  logic              fe, re, sync_low, half_evt, last_half, vs_start, vs_end;
  logic [LINE_W-1:0] low_cnt, line_q;

  vsep_meas #(.LINE_W(LINE_W), .IN_STAGES(IN_STAGES)) u_meas (
    .clk(clk), .rst_n(rst_n), .csync_n(csync_n),
    .fe(fe), .re(re), .sync_low(sync_low), .low_cnt(low_cnt),
    .line_q(line_q), .half_evt(half_evt), .last_half(last_half)
  );

  vsep_vctl #(.LINE_W(LINE_W)) u_vctl (
    .clk(clk), .rst_n(rst_n), .fe(fe), .re(re), .sync_low(sync_low),
    .low_cnt(low_cnt), .line_q(line_q), .vsync_n(vsync_n), .hmute(hs_mute),
    .vs_start(vs_start), .vs_end(vs_end)
  );

  vsep_field u_field (
    .clk(clk), .rst_n(rst_n), .vs_start(vs_start), .vs_end(vs_end),
    .hmute(hs_mute), .half_evt(half_evt), .last_half(last_half),
    .field_odd(field_odd)
  );

  assign line_period = line_q;

  AST_ODD_ON_VS_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(field_odd) |-> $fell(vsync_n)); // R9
  AST_MUTE_DROPS_WITH_VS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vsync_n) |-> !hs_mute); // R6
endmodule

// File: tb/vfield_sep_test.sv
module vfield_sep_test;
  localparam int CLK_PERIOD = 10;
  localparam int LW = 10;
  localparam int L  = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic csync_n = 1'b1;
  logic vsync_n, field_odd, hs_mute;
  logic [LW-1:0] line_period;

  int n = 0;
  int checks = 0;
  int fails = 0;
  int ev_n = 0;
  int vs_a[8];
  int vs_b[8];
  int mu_a[8];
  int mu_b[8];
  bit ev_odd[8];
  string ev_tag[8];
  bit m_ilace = 0;
  bit m_prev = 0;
  int lock_until = 1000000;
  int zero_from = 1000000;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vfield_sep #(.LINE_W(LW), .IN_STAGES(1)) uut (
    .clk(clk), .rst_n(rst_n), .csync_n(csync_n), .vsync_n(vsync_n),
    .field_odd(field_odd), .hs_mute(hs_mute), .line_period(line_period)
  );

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s sample=%0d actual=%0d expected=%0d", req, n, act, exp);
    end
  endtask

  task automatic emit(bit v);
    bit e_vs, e_mu, e_odd;
    string tag;
    @(negedge clk);
    e_vs = 1; e_mu = 0; e_odd = 1; tag = "R10 R3";
    for (int k = 0; k < ev_n; k++) begin
      if (n >= vs_a[k] && n <= vs_b[k]) begin e_vs = 0; tag = ev_tag[k]; end
      if (n >= mu_a[k] && n <= mu_b[k]) e_mu = 1;
      if (n >= vs_a[k]) e_odd = ev_odd[k];
    end
    chk(vsync_n == e_vs, tag, vsync_n, e_vs);
    chk(hs_mute == e_mu, "R6 mute window", hs_mute, e_mu);
    chk(field_odd == e_odd, "R7 R8 R9 parity", field_odd, e_odd);
    if (n < 60) chk(line_period == 0, "R1 unlocked period", line_period, 0);
    if (n >= 70 && n < lock_until) chk(line_period == L, "R2 line period", line_period, L);
    if (n >= zero_from) chk(line_period == 0, "R10 timeout", line_period, 0);
    csync_n = v;
    n++;
  endtask

  task automatic slot(int low, int len);
    for (int i = 0; i < len; i++) emit(i < low ? 1'b0 : 1'b1);
  endtask

  task automatic lines(int cnt);
    for (int i = 0; i < cnt; i++) slot(5, L);
  endtask

  // kind 0: field starting on a line edge, 1: on a half-line edge, 2: unserrated
  task automatic field(int kind);
    int s, f1, r1;
    bit half, seen;
    if (kind == 1) slot(5, L/2);
    s = n;
    half = (kind == 1);
    seen = (kind != 2);
    if (kind == 2) begin
      vs_a[ev_n] = s + L + 2;           // R5 default pulse
      mu_a[ev_n] = s + L/4 + 2;
      ev_tag[ev_n] = "R5 R4";
    end else begin
      f1 = s + 6*(L/2);
      r1 = f1 + 26;
      vs_a[ev_n] = r1 + 2;              // R3 serration start
      mu_a[ev_n] = f1 + L/4 + 2;
      ev_tag[ev_n] = "R3 R4";
    end
    vs_b[ev_n] = vs_a[ev_n] + 3*L - 1;
    mu_b[ev_n] = vs_b[ev_n];
    ev_odd[ev_n] = m_ilace ? !half : 1'b1;
    m_ilace = seen && m_prev;
    m_prev = seen;
    ev_n++;
    if (kind == 2) begin
      slot(197, 4*L);
    end else begin
      for (int i = 0; i < 6; i++) slot(2, L/2);
      for (int i = 0; i < 6; i++) slot(26, L/2);
      for (int i = 0; i < 6; i++) slot(2, L/2);
      if (kind == 1) slot(0, L/2);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(vsync_n == 1, "R1 reset vsync", vsync_n, 1);
    chk(field_odd == 1, "R1 reset field", field_odd, 1);
    chk(hs_mute == 0, "R1 reset mute", hs_mute, 0);
    chk(line_period == 0, "R1 reset period", line_period, 0);
    rst_n = 1'b1;
    lines(20);
    field(0); lines(10);
    field(1); lines(10);
    field(0); lines(10);
    field(1); lines(10);
    field(2); lines(10);
    field(1); lines(10);
    field(1); lines(10);
    field(1); lines(10);
    lock_until = n - L + 1000;
    zero_from = n - L + 1040;
    for (int i = 0; i < 1100; i++) emit(1'b1);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired at sample %0d", n);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule